// File: doc/BRIEF.md
# Segmented Page-Map Address Translator

This block turns a virtual byte address into a physical page number through two table lookups. The first table is a segment map. It is indexed by the current context together with a field of upper address bits, and each entry names a page group. The second table is a page map. It is indexed by that page group and a field of middle address bits. The page entry found there is checked for validity and for write permission. The access then either gets a physical page or is refused with a classified fault.

Both tables are loaded and read back through a register-style map port that carries byte-lane enables. A segment-map write stores a single byte and takes it from one lane. A page-map write merges the enabled lanes into the entry and always clears the entry's third byte. A small context register selects which set of segment entries the lookups use. All translation results are registered and appear one cycle after the request.

Top module: `seg_page_mmu`

## Requirements
- R1: After reset, `ctx_o` is 0, and `xl_vld_o`, `xl_mem_err_o`, `xl_err_inv_o`, `xl_err_prot_o`, `xl_err_wr_o` and `map_rvalid_o` are all low.
- R2: A write on `ctx_we_i` loads `ctx_wdata_i` into the context register, and `ctx_o` shows it one cycle later. Segment entries are stored per context (context ANDed with `CTX_MASK`), so entries written under one context do not change lookups made under another.
- R3: A segment-map write (`map_sel_i`=0) uses the current context and address bits [18 +: SEG_IDX_W] as the index. It stores 7 bits taken from the most significant enabled byte lane. Lane k is `map_wdata_i[8k+7:8k]`, and `map_be_i[3]` is the top lane. A write with no lane enabled stores nothing. A segment read returns `{1'b0, entry[6:0], 24'h0}`.
- R4: A page-map write (`map_sel_i`=1) replaces every enabled byte lane of the selected entry with the write data, keeps the disabled lanes, and forces bits 23:16 to zero whatever the enables are. A page read returns the whole 32-bit entry.
- R5: A translation looks up the segment entry for (context & `CTX_MASK`, vaddr[18 +: SEG_IDX_W]), ANDs it with `PMEG_MASK`, and selects page `group*64 + vaddr[17:12]`. The page entry uses bit 31 as valid, bit 30 as write-enable, and bits [PPN_W-1:0] as the physical page. When the access is allowed, `xl_ppn_o` carries that physical page.
- R6: A read through a page entry whose valid bit is clear raises `xl_mem_err_o` and `xl_err_inv_o` with `xl_err_wr_o` low, and returns a zero `xl_ppn_o`.
- R7: A write through a valid page entry whose write-enable bit is clear is refused. It raises `xl_mem_err_o`, `xl_err_prot_o` and `xl_err_wr_o`, and returns a zero `xl_ppn_o`. A read through the same entry is allowed.
- R8: A write through an invalid page entry raises `xl_mem_err_o`, `xl_err_inv_o` and `xl_err_wr_o`, and leaves `xl_err_prot_o` low.
- R9: Every translation result is registered. It appears in the cycle after the request with `xl_vld_o` high. In a cycle after no request, `xl_vld_o` and every fault flag are low.
- R10: A map-port read is answered in the cycle after the request, with `map_rvalid_o` high and the data on `map_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_we_i | input | 1 | Load the context register |
| ctx_wdata_i | input | CTX_W | New context value |
| ctx_o | output | CTX_W | Current context |
| map_req_i | input | 1 | Map port access strobe |
| map_we_i | input | 1 | Map port write (1) or read (0) |
| map_sel_i | input | 1 | 0 selects the segment map, 1 selects the page map |
| map_addr_i | input | 32 | Byte address that selects the entry |
| map_be_i | input | 4 | Byte-lane enables, bit 3 for bits 31:24 |
| map_wdata_i | input | 32 | Write data |
| map_rvalid_o | output | 1 | Read data valid |
| map_rdata_o | output | 32 | Read data |
| xl_req_i | input | 1 | Translation request |
| xl_we_i | input | 1 | The access being translated is a write |
| xl_vaddr_i | input | 32 | Virtual byte address |
| xl_vld_o | output | 1 | Translation result valid |
| xl_ppn_o | output | PPN_W | Physical page number, zero on a fault |
| xl_mem_err_o | output | 1 | Access refused |
| xl_err_inv_o | output | 1 | Fault cause: invalid page entry |
| xl_err_prot_o | output | 1 | Fault cause: write-protected page |
| xl_err_wr_o | output | 1 | The faulting access was a write |

## Verification
Translation results and map-port read data are due exactly one clock edge after the request is sampled. The context value is due one edge after its write. A table write is visible to a lookup requested at the next edge. The bench drives every stimulus on the falling edge and holds it across one rising edge. It then samples 1 ns after that rising edge, which is the first point where the registered outputs carry the answer. It removes the request on the following falling edge, so every check reads the one result that stimulus produced. Checks that something was ignored read the state back through the map port or a translation before any further write.

// File: rtl/seg_page_mmu_pkg.sv
package seg_page_mmu_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANES     = 4;
  localparam int unsigned SEG_ENT_W = 7;
  localparam int unsigned PG_OFS_W  = 6;
  localparam int unsigned SEG_LSB   = 18;
  localparam int unsigned PG_LSB    = 12;
  localparam int unsigned VALID_BIT = 31;
  localparam int unsigned WPERM_BIT = 30;
  localparam int unsigned ZERO_LANE = 2;

  typedef enum logic {
    MAP_SEG  = 1'b0,
    MAP_PAGE = 1'b1
  } map_sel_e;

  typedef struct packed {
    logic vld;
    logic mem_err;
    logic err_inv;
    logic err_prot;
    logic err_wr;
  } xl_stat_t;
endpackage

// File: rtl/seg_page_mmu_segmap.sv
module seg_page_mmu_segmap
  import seg_page_mmu_pkg::*;
#(
  parameter int unsigned    CTX_W     = 3,
  parameter int unsigned    SEG_IDX_W = 8,
  parameter logic [CTX_W-1:0] CTX_MASK = '1
) (
  input  logic                 clk_i,
  input  logic [CTX_W-1:0]     ctx_i,
  input  logic [SEG_IDX_W-1:0] xl_seg_i,
  input  logic [SEG_IDX_W-1:0] map_seg_i,
  input  logic                 we_i,
  input  logic [LANES-1:0]     be_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [SEG_ENT_W-1:0] xl_ent_o,
  output logic [SEG_ENT_W-1:0] map_ent_o
);
  localparam int unsigned IDX_W = CTX_W + SEG_IDX_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [SEG_ENT_W-1:0] mem_q [DEPTH];
  logic [CTX_W-1:0]     ctx_eff;
  logic [IDX_W-1:0]     xl_idx, map_idx;
  logic [7:0]           lane_byte;

  assign ctx_eff = ctx_i & CTX_MASK;
  assign xl_idx  = {ctx_eff, xl_seg_i};
  assign map_idx = {ctx_eff, map_seg_i};

  // highest enabled lane wins
  always_comb begin
    lane_byte = '0;
    for (int l = 0; l < LANES; l++) begin
      if (be_i[l]) lane_byte = wdata_i[8*l +: 8];
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i && |be_i) mem_q[map_idx] <= lane_byte[SEG_ENT_W-1:0];
  end

  assign xl_ent_o  = mem_q[xl_idx];
  assign map_ent_o = mem_q[map_idx];
endmodule

// File: rtl/seg_page_mmu_pagemap.sv
module seg_page_mmu_pagemap
  import seg_page_mmu_pkg::*;
#(
  parameter int unsigned          PMEG_W    = 5,
  parameter logic [SEG_ENT_W-1:0] PMEG_MASK = 7'h1F
) (
  input  logic                 clk_i,
  input  logic [SEG_ENT_W-1:0] xl_grp_i,
  input  logic [PG_OFS_W-1:0]  xl_pg_i,
  input  logic [SEG_ENT_W-1:0] map_grp_i,
  input  logic [PG_OFS_W-1:0]  map_pg_i,
  input  logic                 we_i,
  input  logic [LANES-1:0]     be_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    xl_pte_o,
  output logic [WORD_W-1:0]    map_pte_o
);
  localparam int unsigned IDX_W = PMEG_W + PG_OFS_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [SEG_ENT_W-1:0] xl_grp_m, map_grp_m;
  logic [IDX_W-1:0]     xl_idx, map_idx;
  logic                 wr_any;

  assign xl_grp_m  = xl_grp_i & PMEG_MASK;
  assign map_grp_m = map_grp_i & PMEG_MASK;
  // group * 64 + page offset
  assign xl_idx    = {xl_grp_m[PMEG_W-1:0], xl_pg_i};
  assign map_idx   = {map_grp_m[PMEG_W-1:0], map_pg_i};
  assign wr_any    = we_i && |be_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == ZERO_LANE) begin : g_zero
      // cleared on every write, never holds data
      logic [DEPTH-1:0] dummy_unused;
      assign dummy_unused = '0;
      assign xl_pte_o[8*l +: 8]  = 8'h00;
      assign map_pte_o[8*l +: 8] = 8'h00;
    end else begin : g_data
      logic [7:0] mem_q [DEPTH];
      always_ff @(posedge clk_i) begin
        if (wr_any && be_i[l]) mem_q[map_idx] <= wdata_i[8*l +: 8];
      end
      assign xl_pte_o[8*l +: 8]  = mem_q[xl_idx];
      assign map_pte_o[8*l +: 8] = mem_q[map_idx];
    end
  end
endmodule

// File: rtl/seg_page_mmu_check.sv
module seg_page_mmu_check
  import seg_page_mmu_pkg::*;
#(
  parameter int unsigned PPN_W = 16
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] pte_i,
  output xl_stat_t          stat_o,
  output logic [PPN_W-1:0]  ppn_o
);
  logic inv, prot;

  assign inv  = req_i && !pte_i[VALID_BIT];
  assign prot = req_i && we_i && pte_i[VALID_BIT] && !pte_i[WPERM_BIT];

  always_comb begin
    stat_o.vld      = req_i;
    stat_o.err_inv  = inv;
    stat_o.err_prot = prot;
    stat_o.mem_err  = inv || prot;
    stat_o.err_wr   = (inv || prot) && we_i;
    ppn_o           = (req_i && !(inv || prot)) ? pte_i[PPN_W-1:0] : '0;
  end
endmodule

// File: rtl/seg_page_mmu.sv
module seg_page_mmu
  import seg_page_mmu_pkg::*;
#(
  parameter int unsigned          CTX_W     = 3,
  parameter logic [CTX_W-1:0]     CTX_MASK  = '1,
  parameter int unsigned          SEG_IDX_W = 8,
  parameter int unsigned          PMEG_W    = 5,
  parameter logic [SEG_ENT_W-1:0] PMEG_MASK = 7'h1F,
  parameter int unsigned          PPN_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctx_we_i,
  input  logic [CTX_W-1:0]  ctx_wdata_i,
  output logic [CTX_W-1:0]  ctx_o,
  input  logic              map_req_i,
  input  logic              map_we_i,
  input  logic              map_sel_i,
  input  logic [31:0]       map_addr_i,
  input  logic [3:0]        map_be_i,
  input  logic [31:0]       map_wdata_i,
  output logic              map_rvalid_o,
  output logic [31:0]       map_rdata_o,
  input  logic              xl_req_i,
  input  logic              xl_we_i,
  input  logic [31:0]       xl_vaddr_i,
  output logic              xl_vld_o,
  output logic [PPN_W-1:0]  xl_ppn_o,
  output logic              xl_mem_err_o,
  output logic              xl_err_inv_o,
  output logic              xl_err_prot_o,
  output logic              xl_err_wr_o
);
  logic [CTX_W-1:0]     ctx_q;
  logic [SEG_ENT_W-1:0] xl_grp, map_grp;
  logic [WORD_W-1:0]    xl_pte, map_pte;
  logic                 seg_we, pg_we, map_rd;
  xl_stat_t             stat_d, stat_q;
  logic [PPN_W-1:0]     ppn_d, ppn_q;
  logic [WORD_W-1:0]    rdata_d, rdata_q;
  logic                 rvalid_q;

  assign seg_we = map_req_i && map_we_i && (map_sel_i == MAP_SEG);
  assign pg_we  = map_req_i && map_we_i && (map_sel_i == MAP_PAGE);
  assign map_rd = map_req_i && !map_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctx_q <= '0;
    else if (ctx_we_i) ctx_q <= ctx_wdata_i;
  end

  seg_page_mmu_segmap #(
    .CTX_W(CTX_W), .SEG_IDX_W(SEG_IDX_W), .CTX_MASK(CTX_MASK)
  ) i_segmap (
    .clk_i     (clk_i),
    .ctx_i     (ctx_q),
    .xl_seg_i  (xl_vaddr_i[SEG_LSB +: SEG_IDX_W]),
    .map_seg_i (map_addr_i[SEG_LSB +: SEG_IDX_W]),
    .we_i      (seg_we),
    .be_i      (map_be_i),
    .wdata_i   (map_wdata_i),
    .xl_ent_o  (xl_grp),
    .map_ent_o (map_grp)
  );

  seg_page_mmu_pagemap #(
    .PMEG_W(PMEG_W), .PMEG_MASK(PMEG_MASK)
  ) i_pagemap (
    .clk_i     (clk_i),
    .xl_grp_i  (xl_grp),
    .xl_pg_i   (xl_vaddr_i[PG_LSB +: PG_OFS_W]),
    .map_grp_i (map_grp),
    .map_pg_i  (map_addr_i[PG_LSB +: PG_OFS_W]),
    .we_i      (pg_we),
    .be_i      (map_be_i),
    .wdata_i   (map_wdata_i),
    .xl_pte_o  (xl_pte),
    .map_pte_o (map_pte)
  );

  seg_page_mmu_check #(.PPN_W(PPN_W)) i_check (
    .req_i  (xl_req_i),
    .we_i   (xl_we_i),
    .pte_i  (xl_pte),
    .stat_o (stat_d),
    .ppn_o  (ppn_d)
  );

  assign rdata_d = (map_sel_i == MAP_PAGE) ? map_pte : {1'b0, map_grp, 24'h0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q   <= '0;
      ppn_q    <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      stat_q   <= stat_d;
      ppn_q    <= ppn_d;
      rvalid_q <= map_rd;
      if (map_rd) rdata_q <= rdata_d;
    end
  end

  assign ctx_o         = ctx_q;
  assign map_rvalid_o  = rvalid_q;
  assign map_rdata_o   = rdata_q;
  assign xl_vld_o      = stat_q.vld;
  assign xl_ppn_o      = ppn_q;
  assign xl_mem_err_o  = stat_q.mem_err;
  assign xl_err_inv_o  = stat_q.err_inv;
  assign xl_err_prot_o = stat_q.err_prot;
  assign xl_err_wr_o   = stat_q.err_wr;
endmodule

// File: rtl/seg_page_mmu_chk.sv
module seg_page_mmu_chk #(
  parameter int unsigned CTX_W = 3,
  parameter int unsigned PPN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctx_we_i,
  input logic [CTX_W-1:0] ctx_wdata_i,
  input logic [CTX_W-1:0] ctx_o,
  input logic             map_req_i,
  input logic             map_we_i,
  input logic             map_rvalid_o,
  input logic             xl_req_i,
  input logic             xl_we_i,
  input logic             xl_vld_o,
  input logic [PPN_W-1:0] xl_ppn_o,
  input logic             xl_mem_err_o,
  input logic             xl_err_inv_o,
  input logic             xl_err_prot_o,
  input logic             xl_err_wr_o
);
  // R9
  req_gives_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_i |=> xl_vld_o);
  // R9
  idle_is_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xl_req_i |=> !xl_vld_o && !xl_mem_err_o && !xl_err_inv_o && !xl_err_prot_o);
  // R6
  fault_zero_ppn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_mem_err_o |-> xl_vld_o && xl_ppn_o == '0);
  // R6
  read_fault_not_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_i && !xl_we_i |=> !xl_err_wr_o && !xl_err_prot_o);
  // R7
  prot_only_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_err_prot_o |-> xl_err_wr_o && xl_mem_err_o);
  // R8
  single_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xl_err_inv_o, xl_err_prot_o}) && (xl_mem_err_o == (xl_err_inv_o || xl_err_prot_o)));
  // R2
  ctx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_we_i |=> ctx_o == $past(ctx_wdata_i));
  // R10
  map_read_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_req_i && !map_we_i |=> map_rvalid_o);
endmodule

bind seg_page_mmu seg_page_mmu_chk #(.CTX_W(CTX_W), .PPN_W(PPN_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctx_we_i      (ctx_we_i),
  .ctx_wdata_i   (ctx_wdata_i),
  .ctx_o         (ctx_o),
  .map_req_i     (map_req_i),
  .map_we_i      (map_we_i),
  .map_rvalid_o  (map_rvalid_o),
  .xl_req_i      (xl_req_i),
  .xl_we_i       (xl_we_i),
  .xl_vld_o      (xl_vld_o),
  .xl_ppn_o      (xl_ppn_o),
  .xl_mem_err_o  (xl_mem_err_o),
  .xl_err_inv_o  (xl_err_inv_o),
  .xl_err_prot_o (xl_err_prot_o),
  .xl_err_wr_o   (xl_err_wr_o)
);

// File: tb/test_seg_page_mmu.sv
`timescale 1ns/1ps
module test_seg_page_mmu;
  localparam int unsigned CTX_W = 3;
  localparam int unsigned PPN_W = 16;
  // group field at [25:18], page field at [17:12]
  localparam logic [31:0] VA1 = 32'h0048_5000; // seg 0x12, page 5
  localparam logic [31:0] VA6 = 32'h0048_6000; // seg 0x12, page 6
  localparam logic [31:0] VA7 = 32'h0048_7000; // seg 0x12, page 7

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ctx_we_i = 1'b0;
  logic [CTX_W-1:0]  ctx_wdata_i = '0;
  logic [CTX_W-1:0]  ctx_o;
  logic              map_req_i = 1'b0, map_we_i = 1'b0, map_sel_i = 1'b0;
  logic [31:0]       map_addr_i = '0, map_wdata_i = '0;
  logic [3:0]        map_be_i = '0;
  logic              map_rvalid_o;
  logic [31:0]       map_rdata_o;
  logic              xl_req_i = 1'b0, xl_we_i = 1'b0;
  logic [31:0]       xl_vaddr_i = '0;
  logic              xl_vld_o, xl_mem_err_o, xl_err_inv_o, xl_err_prot_o, xl_err_wr_o;
  logic [PPN_W-1:0]  xl_ppn_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  seg_page_mmu i_seg_page_mmu (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctx_we_i(ctx_we_i), .ctx_wdata_i(ctx_wdata_i), .ctx_o(ctx_o),
    .map_req_i(map_req_i), .map_we_i(map_we_i), .map_sel_i(map_sel_i),
    .map_addr_i(map_addr_i), .map_be_i(map_be_i), .map_wdata_i(map_wdata_i),
    .map_rvalid_o(map_rvalid_o), .map_rdata_o(map_rdata_o),
    .xl_req_i(xl_req_i), .xl_we_i(xl_we_i), .xl_vaddr_i(xl_vaddr_i),
    .xl_vld_o(xl_vld_o), .xl_ppn_o(xl_ppn_o), .xl_mem_err_o(xl_mem_err_o),
    .xl_err_inv_o(xl_err_inv_o), .xl_err_prot_o(xl_err_prot_o), .xl_err_wr_o(xl_err_wr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ctx(input logic [CTX_W-1:0] c);
    @(negedge clk_i);
    ctx_we_i = 1'b1; ctx_wdata_i = c;
    @(negedge clk_i);
    ctx_we_i = 1'b0;
  endtask

  task automatic map_wr(input logic sel, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk_i);
    map_req_i = 1'b1; map_we_i = 1'b1; map_sel_i = sel;
    map_addr_i = a; map_be_i = be; map_wdata_i = d;
    @(negedge clk_i);
    map_req_i = 1'b0; map_we_i = 1'b0;
  endtask

  task automatic map_rd(input logic sel, input logic [31:0] a, output logic [31:0] d,
                        output logic v);
    @(negedge clk_i);
    map_req_i = 1'b1; map_we_i = 1'b0; map_sel_i = sel; map_addr_i = a;
    @(posedge clk_i); #1;
    d = map_rdata_o; v = map_rvalid_o;
    @(negedge clk_i);
    map_req_i = 1'b0;
  endtask

  // returns {vld, mem_err, inv, prot, wr} and ppn
  task automatic xlate(input logic we, input logic [31:0] va, output logic [4:0] st,
                       output logic [PPN_W-1:0] ppn);
    @(negedge clk_i);
    xl_req_i = 1'b1; xl_we_i = we; xl_vaddr_i = va;
    @(posedge clk_i); #1;
    st  = {xl_vld_o, xl_mem_err_o, xl_err_inv_o, xl_err_prot_o, xl_err_wr_o};
    ppn = xl_ppn_o;
    @(negedge clk_i);
    xl_req_i = 1'b0; xl_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctx", 32'(ctx_o), 32'h0);
    check("R1 flags", {27'h0, xl_vld_o, xl_mem_err_o, xl_err_inv_o, xl_err_prot_o, xl_err_wr_o}, 32'h0);
    check("R1 rvalid", 32'(map_rvalid_o), 32'h0);
  endtask

  task automatic t_ctx();
    @(negedge clk_i);
    ctx_we_i = 1'b1; ctx_wdata_i = 3'd5;
    @(posedge clk_i); #1;
    check("R2 ctx load", 32'(ctx_o), 32'h5);
    @(negedge clk_i);
    ctx_we_i = 1'b0;
  endtask

  task automatic t_seg_lane();
    logic [31:0] d; logic v;
    map_wr(1'b0, VA1, 4'b0110, 32'h00A5_3300);
    map_rd(1'b0, VA1, d, v);
    check("R10 seg rvalid", 32'(v), 32'h1);
    check("R3 top enabled lane, 7 bits", d, 32'h2500_0000);
    map_wr(1'b0, VA1, 4'b0000, 32'h1111_1111);
    map_rd(1'b0, VA1, d, v);
    check("R3 no lane no write", d, 32'h2500_0000);
    map_wr(1'b0, VA1, 4'b0001, 32'h0000_00FF);
    map_rd(1'b0, VA1, d, v);
    check("R3 low lane", d, 32'h7F00_0000);
    map_wr(1'b0, VA1, 4'b1111, 32'h0344_5566);
    map_rd(1'b0, VA1, d, v);
    check("R3 full word lane 3", d, 32'h0300_0000);
  endtask

  task automatic t_page();
    logic [31:0] d; logic v;
    map_wr(1'b1, VA1, 4'b1111, 32'hC0AB_1234);
    map_rd(1'b1, VA1, d, v);
    check("R10 page rvalid", 32'(v), 32'h1);
    check("R4 full write clears 23:16", d, 32'hC000_1234);
    map_wr(1'b1, VA1, 4'b0001, 32'hFFFF_FF56);
    map_rd(1'b1, VA1, d, v);
    check("R4 merge low lane", d, 32'hC000_1256);
    map_wr(1'b1, VA1, 4'b0100, 32'h00FF_0000);
    map_rd(1'b1, VA1, d, v);
    check("R4 lane 2 forced zero", d, 32'hC000_1256);
  endtask

  task automatic t_xlate_ok();
    logic [4:0] st; logic [PPN_W-1:0] p;
    xlate(1'b0, VA1, st, p);
    check("R5 read ok status", 32'(st), 32'b10000);
    check("R5 read ppn", 32'(p), 32'h1256);
    xlate(1'b1, VA1, st, p);
    check("R5 write ok status", 32'(st), 32'b10000);
    check("R5 write ppn", 32'(p), 32'h1256);
  endtask

  task automatic t_prot();
    logic [4:0] st; logic [PPN_W-1:0] p;
    map_wr(1'b1, VA6, 4'b1111, 32'h8000_0077);
    xlate(1'b0, VA6, st, p);
    check("R7 read allowed", 32'(st), 32'b10000);
    check("R7 read ppn", 32'(p), 32'h77);
    xlate(1'b1, VA6, st, p);
    check("R7 prot status", 32'(st), 32'b11011);
    check("R7 prot ppn", 32'(p), 32'h0);
  endtask

  task automatic t_invalid();
    logic [4:0] st; logic [PPN_W-1:0] p;
    map_wr(1'b1, VA7, 4'b1111, 32'h4000_0099);
    xlate(1'b0, VA7, st, p);
    check("R6 invalid read status", 32'(st), 32'b11100);
    check("R6 invalid read ppn", 32'(p), 32'h0);
    xlate(1'b1, VA7, st, p);
    check("R8 invalid write status", 32'(st), 32'b11101);
    check("R8 invalid write ppn", 32'(p), 32'h0);
  endtask

  task automatic t_ctx_iso();
    logic [4:0] st; logic [PPN_W-1:0] p;
    set_ctx(3'd2);
    map_wr(1'b0, VA1, 4'b1000, 32'h0400_0000);
    map_wr(1'b1, VA1, 4'b1111, 32'hC000_0AAA);
    xlate(1'b0, VA1, st, p);
    check("R2 ctx2 ppn", 32'(p), 32'h0AAA);
    set_ctx(3'd1);
    map_wr(1'b0, VA1, 4'b1000, 32'h2300_0000);
    xlate(1'b0, VA1, st, p);
    check("R5 group mask 0x23->3", 32'(p), 32'h1256);
    set_ctx(3'd5);
    xlate(1'b0, VA1, st, p);
    check("R2 ctx5 untouched", 32'(p), 32'h1256);
    set_ctx(3'd2);
    xlate(1'b0, VA1, st, p);
    check("R2 ctx2 kept", 32'(p), 32'h0AAA);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    xl_req_i = 1'b0;
    @(posedge clk_i); #1;
    check("R9 idle", {27'h0, xl_vld_o, xl_mem_err_o, xl_err_inv_o, xl_err_prot_o, xl_err_wr_o}, 32'h0);
    check("R10 no read no rvalid", 32'(map_rvalid_o), 32'h0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ctx();
    t_seg_lane();
    t_page();
    t_xlate_ok();
    t_prot();
    t_invalid();
    t_ctx_iso();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule